// File: doc/BRIEF.md
# Register-Group Memory Sequencer

This block turns one unit-stride vector load or store that names a register group into a chain of single-register memory micro-operations. A command carries a base address, the first register of the group, a group size code (1, 2, 4 or 8 registers), an element width code, the number of elements that fit in one register, and the total number of elements to move. The block then issues one micro-operation per register, lowest register first. Each micro-operation carries the register index, the byte address where that register's slice begins, the number of active elements in it, and a flag that marks the final one.

A short final slice is trimmed in hardware. Once the element count runs out, no further registers are touched. A command that asks for nothing completes at once. A command whose group is misaligned, runs off the register file, or states zero elements per register is refused with a one-cycle flag. Loads and stores are sequenced in exactly the same way; the direction bit only travels with each micro-operation.

Top module: `rgrp_seq`

## Requirements
- R1: `cmd_ready_o` is high exactly when no sequence is in progress. A command is taken on a cycle with `cmd_valid_i` and `cmd_ready_o` both high. While a sequence runs, `cmd_valid_i` has no effect.
- R2: The group size code `cmd_lmul_i` = 0,1,2,3 selects 1,2,4,8 registers. A command is illegal when `cmd_vreg_i` is not a multiple of the group size, when the group would pass register 31, or when `cmd_cap_i` is 0. An illegal command raises `illegal_o` for one cycle, one cycle after it is taken. It issues no micro-operation and no `done_o`.
- R3: Micro-operations carry registers `cmd_vreg_i`, `cmd_vreg_i`+1, … in ascending order, one per handshake. The first is valid the cycle after the command is taken, and `uop_valid_o` stays high until the final handshake.
- R4: Each `uop_cnt_o` equals the smaller of the remaining element count and `cmd_cap_i`. The remaining count is then reduced by that amount.
- R5: The width code `cmd_ew_i` = 0,1,2,3 selects 1,2,4,8-byte elements. The first address is `cmd_addr_i`. Each following address is the previous one plus the previous `uop_cnt_o` times the element bytes.
- R6: The sequence ends with the register that uses up the remaining count, or with the last register of the group, whichever comes first. `uop_last_o` is high on that micro-operation only.
- R7: A legal command with `cmd_total_i` = 0 issues no micro-operation and raises `done_o` the cycle after it is taken.
- R8: `done_o` is a one-cycle pulse in the cycle after the final handshake. In that same cycle `cmd_ready_o` is high.
- R9: While `uop_valid_o` is high and `uop_ready_i` is low, every micro-operation output holds its value. No register is skipped or repeated.
- R10: `uop_store_o` equals the command's `cmd_store_i` on every micro-operation, and loads and stores produce identical sequences.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cmd_valid_i | input | 1 | Command offered |
| cmd_ready_o | output | 1 | Sequencer idle, command can be taken |
| cmd_store_i | input | 1 | 1 = store, 0 = load |
| cmd_addr_i | input | ADDR_W | Base byte address |
| cmd_vreg_i | input | VREG_W | First register of the group |
| cmd_total_i | input | CNT_W | Total element count |
| cmd_ew_i | input | 2 | Element width code (1,2,4,8 bytes) |
| cmd_lmul_i | input | 2 | Group size code (1,2,4,8 registers) |
| cmd_cap_i | input | CNT_W | Elements per register |
| uop_valid_o | output | 1 | Micro-operation valid |
| uop_ready_i | input | 1 | Micro-operation accepted |
| uop_store_o | output | 1 | Direction of the micro-operation |
| uop_vreg_o | output | VREG_W | Target register |
| uop_addr_o | output | ADDR_W | Start byte address |
| uop_cnt_o | output | CNT_W | Active element count |
| uop_last_o | output | 1 | Final micro-operation of the command |
| done_o | output | 1 | Completion pulse |
| illegal_o | output | 1 | Refused-command pulse |

## Verification
The completion pulse and the intake of the next command can land in the same cycle, because the sequencer goes idle at the edge of the final handshake. The bench offers a new command in the very cycle where `done_o` of the previous one is high. It checks that the pulse is present, that `cmd_ready_o` is high alongside it, and that the new command's first micro-operation appears one cycle later with the correct register, address and count. A zero-length command placed straight after a completion also yields two adjacent `done_o` pulses, which confirms that each pulse belongs to its own command.

// File: rtl/rgrp_pkg.sv
package rgrp_pkg;
  typedef enum logic [1:0] {EW_B1 = 2'd0, EW_B2 = 2'd1, EW_B4 = 2'd2, EW_B8 = 2'd3} ew_e;
  typedef enum logic [1:0] {GRP_1 = 2'd0, GRP_2 = 2'd1, GRP_4 = 2'd2, GRP_8 = 2'd3} grp_e;
  localparam int unsigned GRP_IDX_W = 3;
endpackage

// File: rtl/rgrp_cmd_check.sv
module rgrp_cmd_check
  import rgrp_pkg::*;
#(
  parameter int unsigned NUM_VREGS = 32,
  parameter int unsigned VREG_W    = 5,
  parameter int unsigned CNT_W     = 12
) (
  input  logic [VREG_W-1:0]    vreg_i,
  input  grp_e                 grp_i,
  input  logic [CNT_W-1:0]     cap_i,
  output logic [GRP_IDX_W-1:0] last_idx_o,
  output logic                 illegal_o
);
  localparam int unsigned SPAN_W = VREG_W + 1;

  logic [GRP_IDX_W:0] nregs;
  logic               misalign;
  logic               overrun;

  always_comb begin
    nregs      = (GRP_IDX_W+1)'(1) << grp_i;
    last_idx_o = GRP_IDX_W'(nregs - 1'b1);
    misalign   = (vreg_i & VREG_W'(last_idx_o)) != '0;
    overrun    = ({1'b0, vreg_i} + SPAN_W'(nregs)) > SPAN_W'(NUM_VREGS);
    illegal_o  = misalign | overrun | (cap_i == '0);
  end
endmodule

// File: rtl/rgrp_slice.sv
module rgrp_slice
  import rgrp_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned CNT_W  = 12
) (
  input  logic [CNT_W-1:0]  rem_i,
  input  logic [CNT_W-1:0]  cap_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  ew_e               ew_i,
  output logic [CNT_W-1:0]  cnt_o,
  output logic [CNT_W-1:0]  rem_next_o,
  output logic [ADDR_W-1:0] addr_next_o,
  output logic              exhaust_o
);
  always_comb begin
    exhaust_o   = rem_i <= cap_i;
    cnt_o       = exhaust_o ? rem_i : cap_i;
    rem_next_o  = rem_i - cnt_o;
    addr_next_o = addr_i + (ADDR_W'(cnt_o) << ew_i);
  end
endmodule

// File: rtl/rgrp_ctrl.sv
module rgrp_ctrl
  import rgrp_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned CNT_W  = 12,
  parameter int unsigned VREG_W = 5
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 cmd_valid_i,
  output logic                 cmd_ready_o,
  input  logic                 cmd_store_i,
  input  logic [ADDR_W-1:0]    cmd_addr_i,
  input  logic [VREG_W-1:0]    cmd_vreg_i,
  input  logic [CNT_W-1:0]     cmd_total_i,
  input  ew_e                  cmd_ew_i,
  input  logic [CNT_W-1:0]     cmd_cap_i,
  input  logic                 cmd_illegal_i,
  input  logic [GRP_IDX_W-1:0] cmd_last_idx_i,
  input  logic [CNT_W-1:0]     cnt_i,
  input  logic [CNT_W-1:0]     rem_next_i,
  input  logic [ADDR_W-1:0]    addr_next_i,
  input  logic                 exhaust_i,
  output logic [CNT_W-1:0]     rem_o,
  output logic [CNT_W-1:0]     cap_o,
  output ew_e                  ew_o,
  output logic                 uop_valid_o,
  input  logic                 uop_ready_i,
  output logic                 uop_store_o,
  output logic [VREG_W-1:0]    uop_vreg_o,
  output logic [ADDR_W-1:0]    uop_addr_o,
  output logic                 uop_last_o,
  output logic                 done_o,
  output logic                 illegal_o
);
  logic                 busy_q;
  logic                 store_q;
  logic [VREG_W-1:0]    vreg_q;
  logic [ADDR_W-1:0]    addr_q;
  logic [CNT_W-1:0]     rem_q;
  logic [CNT_W-1:0]     cap_q;
  ew_e                  ew_q;
  logic [GRP_IDX_W-1:0] idx_q;
  logic [GRP_IDX_W-1:0] last_idx_q;
  logic                 done_q;
  logic                 illegal_q;
  logic                 cmd_fire;
  logic                 uop_fire;

  assign cmd_ready_o = ~busy_q;
  assign cmd_fire    = cmd_valid_i & ~busy_q;
  assign uop_fire    = busy_q & uop_ready_i;

  assign uop_valid_o = busy_q;
  assign uop_store_o = store_q;
  assign uop_vreg_o  = vreg_q;
  assign uop_addr_o  = addr_q;
  // group end or data end, whichever first
  assign uop_last_o  = exhaust_i | (idx_q == last_idx_q);
  assign rem_o       = rem_q;
  assign cap_o       = cap_q;
  assign ew_o        = ew_q;
  assign done_o      = done_q;
  assign illegal_o   = illegal_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q     <= 1'b0;
      store_q    <= 1'b0;
      vreg_q     <= '0;
      addr_q     <= '0;
      rem_q      <= '0;
      cap_q      <= '0;
      ew_q       <= EW_B1;
      idx_q      <= '0;
      last_idx_q <= '0;
      done_q     <= 1'b0;
      illegal_q  <= 1'b0;
    end else begin
      done_q    <= 1'b0;
      illegal_q <= 1'b0;
      if (cmd_fire) begin
        if (cmd_illegal_i) begin
          illegal_q <= 1'b1;
        end else if (cmd_total_i == '0) begin
          done_q <= 1'b1;
        end else begin
          busy_q     <= 1'b1;
          store_q    <= cmd_store_i;
          vreg_q     <= cmd_vreg_i;
          addr_q     <= cmd_addr_i;
          rem_q      <= cmd_total_i;
          cap_q      <= cmd_cap_i;
          ew_q       <= cmd_ew_i;
          idx_q      <= '0;
          last_idx_q <= cmd_last_idx_i;
        end
      end else if (uop_fire) begin
        if (uop_last_o) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end else begin
          vreg_q <= vreg_q + 1'b1;
          addr_q <= addr_next_i;
          rem_q  <= rem_next_i;
          idx_q  <= idx_q + 1'b1;
        end
      end
    end
  end

  AST_UOP_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    uop_valid_o && !uop_ready_i |=> uop_valid_o && $stable(uop_vreg_o) && $stable(uop_addr_o)
      && $stable(rem_q) && $stable(uop_store_o)); // R9

  AST_VREG_ASCEND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    uop_valid_o && uop_ready_i && !uop_last_o |=> uop_valid_o
      && (uop_vreg_o == $past(uop_vreg_o) + 1'b1)); // R3

  AST_ADDR_ADVANCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    uop_valid_o && uop_ready_i && !uop_last_o |=>
      uop_addr_o == $past(uop_addr_o) + ($past(ADDR_W'(cnt_i)) * (ADDR_W'(1) << ew_q))); // R5

  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    uop_valid_o |-> (cnt_i != '0) && (cnt_i <= cap_q)); // R4

  AST_DONE_AFTER_LAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    uop_valid_o && uop_ready_i && uop_last_o |=> done_o && !uop_valid_o && cmd_ready_o); // R8

  AST_ILLEGAL_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> !uop_valid_o && !done_o); // R2

  AST_BUSY_IGNORES_CMD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    uop_valid_o && !uop_ready_i |=> $stable(uop_vreg_o) && !illegal_o && !done_o); // R1
endmodule

// File: rtl/rgrp_seq.sv
module rgrp_seq
  import rgrp_pkg::*;
#(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned CNT_W     = 12,
  parameter int unsigned NUM_VREGS = 32,
  parameter int unsigned VREG_W    = $clog2(NUM_VREGS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  output logic              cmd_ready_o,
  input  logic              cmd_store_i,
  input  logic [ADDR_W-1:0] cmd_addr_i,
  input  logic [VREG_W-1:0] cmd_vreg_i,
  input  logic [CNT_W-1:0]  cmd_total_i,
  input  logic [1:0]        cmd_ew_i,
  input  logic [1:0]        cmd_lmul_i,
  input  logic [CNT_W-1:0]  cmd_cap_i,
  output logic              uop_valid_o,
  input  logic              uop_ready_i,
  output logic              uop_store_o,
  output logic [VREG_W-1:0] uop_vreg_o,
  output logic [ADDR_W-1:0] uop_addr_o,
  output logic [CNT_W-1:0]  uop_cnt_o,
  output logic              uop_last_o,
  output logic              done_o,
  output logic              illegal_o
);
  logic [GRP_IDX_W-1:0] last_idx;
  logic                 cmd_illegal;
  logic [CNT_W-1:0]     rem;
  logic [CNT_W-1:0]     cap;
  ew_e                  ew;
  logic [CNT_W-1:0]     cnt;
  logic [CNT_W-1:0]     rem_next;
  logic [ADDR_W-1:0]    addr_next;
  logic                 exhaust;

  rgrp_cmd_check #(
    .NUM_VREGS(NUM_VREGS),
    .VREG_W   (VREG_W),
    .CNT_W    (CNT_W)
  ) u_check (
    .vreg_i    (cmd_vreg_i),
    .grp_i     (grp_e'(cmd_lmul_i)),
    .cap_i     (cmd_cap_i),
    .last_idx_o(last_idx),
    .illegal_o (cmd_illegal)
  );

  rgrp_slice #(
    .ADDR_W(ADDR_W),
    .CNT_W (CNT_W)
  ) u_slice (
    .rem_i      (rem),
    .cap_i      (cap),
    .addr_i     (uop_addr_o),
    .ew_i       (ew),
    .cnt_o      (cnt),
    .rem_next_o (rem_next),
    .addr_next_o(addr_next),
    .exhaust_o  (exhaust)
  );

  rgrp_ctrl #(
    .ADDR_W(ADDR_W),
    .CNT_W (CNT_W),
    .VREG_W(VREG_W)
  ) u_ctrl (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .cmd_valid_i   (cmd_valid_i),
    .cmd_ready_o   (cmd_ready_o),
    .cmd_store_i   (cmd_store_i),
    .cmd_addr_i    (cmd_addr_i),
    .cmd_vreg_i    (cmd_vreg_i),
    .cmd_total_i   (cmd_total_i),
    .cmd_ew_i      (ew_e'(cmd_ew_i)),
    .cmd_cap_i     (cmd_cap_i),
    .cmd_illegal_i (cmd_illegal),
    .cmd_last_idx_i(last_idx),
    .cnt_i         (cnt),
    .rem_next_i    (rem_next),
    .addr_next_i   (addr_next),
    .exhaust_i     (exhaust),
    .rem_o         (rem),
    .cap_o         (cap),
    .ew_o          (ew),
    .uop_valid_o   (uop_valid_o),
    .uop_ready_i   (uop_ready_i),
    .uop_store_o   (uop_store_o),
    .uop_vreg_o    (uop_vreg_o),
    .uop_addr_o    (uop_addr_o),
    .uop_last_o    (uop_last_o),
    .done_o        (done_o),
    .illegal_o     (illegal_o)
  );

  assign uop_cnt_o = cnt;

  AST_ILLEGAL_REFUSED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_i && cmd_ready_o && cmd_illegal |=> illegal_o && !uop_valid_o); // R2

  AST_ZERO_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_i && cmd_ready_o && !cmd_illegal && (cmd_total_i == '0) |=> done_o && !uop_valid_o); // R7
endmodule

// File: tb/rgrp_seq_tb.sv
`timescale 1ns/1ps
module rgrp_seq_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cmd_valid_i = 1'b0;
  logic        cmd_ready_o;
  logic        cmd_store_i = 1'b0;
  logic [31:0] cmd_addr_i = '0;
  logic [4:0]  cmd_vreg_i = '0;
  logic [11:0] cmd_total_i = '0;
  logic [1:0]  cmd_ew_i = '0;
  logic [1:0]  cmd_lmul_i = '0;
  logic [11:0] cmd_cap_i = '0;
  logic        uop_valid_o;
  logic        uop_ready_i = 1'b0;
  logic        uop_store_o;
  logic [4:0]  uop_vreg_o;
  logic [31:0] uop_addr_o;
  logic [11:0] uop_cnt_o;
  logic        uop_last_o;
  logic        done_o;
  logic        illegal_o;

  int n_run = 0;
  int n_fail = 0;

  always #4 clk_i = ~clk_i;

  rgrp_seq u_dut (
    .clk_i, .rst_ni, .cmd_valid_i, .cmd_ready_o, .cmd_store_i, .cmd_addr_i,
    .cmd_vreg_i, .cmd_total_i, .cmd_ew_i, .cmd_lmul_i, .cmd_cap_i,
    .uop_valid_o, .uop_ready_i, .uop_store_o, .uop_vreg_o, .uop_addr_o,
    .uop_cnt_o, .uop_last_o, .done_o, .illegal_o
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Caller sits at a negedge; returns at the negedge where done_o is expected.
  task automatic run_seq(input bit st, input logic [31:0] base, input int vreg,
                         input int total, input int ew, input int lmul, input int cap,
                         input bit stall, input bit junk);
    int n, nb, exp_n, rem, k, guard, c;
    int exp_cnt[8];
    logic [31:0] exp_addr[8];
    logic [31:0] a;
    bit bad, stalled, rdy;
    n  = 1 << lmul;
    nb = 1 << ew;
    bad = (cap == 0) || (vreg % n != 0) || (vreg + n > 32);
    exp_n = 0; rem = total; a = base;
    while (exp_n < n && rem > 0) begin
      c = (rem < cap) ? rem : cap;
      exp_cnt[exp_n]  = c;
      exp_addr[exp_n] = a;
      a   = a + 32'(c * nb);
      rem = rem - c;
      exp_n++;
    end
    chk(cmd_ready_o === 1'b1, "R1", "ready before command", cmd_ready_o, 1);
    cmd_store_i = st; cmd_addr_i = base; cmd_vreg_i = 5'(vreg);
    cmd_total_i = 12'(total); cmd_ew_i = 2'(ew); cmd_lmul_i = 2'(lmul); cmd_cap_i = 12'(cap);
    cmd_valid_i = 1'b1;
    @(negedge clk_i);
    cmd_valid_i = junk && !bad && total != 0;
    if (junk) begin
      cmd_vreg_i = 5'd0; cmd_total_i = 12'd1;
    end
    if (bad) begin
      chk(illegal_o === 1'b1, "R2", "illegal pulse", illegal_o, 1);
      chk(uop_valid_o === 1'b0 && done_o === 1'b0, "R2", "no uop/done on illegal", uop_valid_o, 0);
      @(negedge clk_i);
      chk(illegal_o === 1'b0 && uop_valid_o === 1'b0, "R2", "illegal single pulse", illegal_o, 0);
      return;
    end
    if (total == 0) begin
      chk(done_o === 1'b1, "R7", "zero count done", done_o, 1);
      chk(uop_valid_o === 1'b0, "R7", "zero count no uop", uop_valid_o, 0);
      return;
    end
    k = 0; guard = 0; stalled = 0;
    while (k < exp_n && guard < 200) begin
      guard++;
      chk(uop_valid_o === 1'b1, "R3", "uop valid", uop_valid_o, 1);
      if (uop_valid_o !== 1'b1) break;
      chk(cmd_ready_o === 1'b0, "R1", "ready low while busy", cmd_ready_o, 0);
      chk(uop_vreg_o == 5'(vreg + k), "R3", "uop vreg", uop_vreg_o, vreg + k);
      chk(uop_cnt_o == 12'(exp_cnt[k]), "R4", "uop count", uop_cnt_o, exp_cnt[k]);
      chk(uop_addr_o == exp_addr[k], "R5", "uop address", uop_addr_o, exp_addr[k]);
      chk(uop_last_o == (k == exp_n - 1), "R6", "uop last flag", uop_last_o, k == exp_n - 1);
      chk(uop_store_o == st, "R10", "uop direction", uop_store_o, st);
      if (stall && !stalled) begin rdy = 0; stalled = 1; end
      else begin rdy = 1; stalled = 0; end
      if (rdy && k == exp_n - 1) cmd_valid_i = 1'b0;
      uop_ready_i = rdy;
      @(negedge clk_i);
      if (rdy) k++;
    end
    uop_ready_i = 1'b0;
    cmd_valid_i = 1'b0;
    chk(k == exp_n, "R6", "uop total", k, exp_n);
    chk(done_o === 1'b1, "R8", "done after last", done_o, 1);
    chk(uop_valid_o === 1'b0, "R6", "no uop past end", uop_valid_o, 0);
    chk(cmd_ready_o === 1'b1, "R8", "ready with done", cmd_ready_o, 1);
  endtask

  task automatic idle_after(input string req);
    @(negedge clk_i);
    chk(done_o === 1'b0, req, "done single pulse", done_o, 0);
    chk(uop_valid_o === 1'b0, req, "stays idle", uop_valid_o, 0);
  endtask

  task automatic t_reset;
    chk(cmd_ready_o === 1'b1 && uop_valid_o === 1'b0, "R1", "reset idle", uop_valid_o, 0);
    chk(done_o === 1'b0 && illegal_o === 1'b0, "R1", "reset pulses low", done_o, 0);
  endtask

  task automatic t_full_group;  // R3 R4 R5: 8 regs, byte elements, load
    run_seq(1'b0, 32'h1000, 0, 128, 0, 3, 16, 1'b0, 1'b0);
    idle_after("R8");
  endtask

  task automatic t_partial;     // R6 R10: 37 words over cap 16, store
    run_seq(1'b1, 32'h2000_0040, 8, 37, 2, 3, 16, 1'b0, 1'b0);
    idle_after("R6");
  endtask

  task automatic t_stall;       // R9 R1: stall each uop, stray commands while busy
    run_seq(1'b0, 32'h0000_0100, 4, 40, 1, 2, 10, 1'b1, 1'b1);
    idle_after("R9");
  endtask

  task automatic t_zero;        // R7
    run_seq(1'b0, 32'h300, 16, 0, 0, 2, 8, 1'b0, 1'b0);
    idle_after("R7");
  endtask

  task automatic t_illegal;     // R2: misaligned and zero capacity
    run_seq(1'b0, 32'h400, 3, 10, 0, 2, 8, 1'b0, 1'b0);
    run_seq(1'b1, 32'h400, 8, 10, 0, 3, 0, 1'b0, 1'b0);
    run_seq(1'b0, 32'h400, 30, 10, 0, 1, 8, 1'b0, 1'b0);
    chk(cmd_ready_o === 1'b1, "R2", "idle after refusals", cmd_ready_o, 1);
  endtask

  task automatic t_overflow_b2b; // R6 group end, then back-to-back command with done
    run_seq(1'b1, 32'hFFFF_FFC0, 30, 100, 3, 1, 8, 1'b0, 1'b0);
    run_seq(1'b0, 32'h55, 5, 3, 0, 0, 8, 1'b0, 1'b0);
    run_seq(1'b0, 32'h60, 0, 0, 0, 0, 8, 1'b0, 1'b0);
    idle_after("R7");
    run_seq(1'b1, 32'h80, 7, 8, 0, 0, 8, 1'b1, 1'b0);
    idle_after("R10");
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_full_group();
    t_partial();
    t_stall();
    t_zero();
    t_illegal();
    t_overflow_b2b();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule